// File: doc/BRIEF.md
# Dual-Width One-Time-Programmable ROM Model

This block is a synthesizable behavioural model of a one-time-programmable memory read either as 16-bit words or as 8-bit bytes. A width-select input picks the organisation. In byte organisation the topmost data pin acts as an extra, lowest-order address input. That input chooses which half of the stored word appears on the low eight data lanes. Each data lane has its own output enable, so a lane that must float is reported as undriven.

Chip enable and output enable are both active low and both must be asserted before anything is driven. A signature mode, entered through a high-voltage flag on the signature address pin, returns a two-entry identifier selected by address bit 0. Programming takes place at the end of a low pulse on chip enable. It needs the program-voltage flag, output enable high and word organisation. Cells start at all ones and a program can only clear bits. An attempt made in byte organisation is discarded and raises a sticky error flag. Analog levels appear only as boolean flags, and timing delays are not modelled.

Top module: `otp_dual_rom`

## Requirements
- R1: With ce_ni=0, oe_ni=0, sig_hv_i=0 and wide_i=1, dq_o carries the full stored word at addr_i and dq_oe_o is 16'hFFFF.
- R2: With ce_ni=0, oe_ni=0, sig_hv_i=0 and wide_i=0, dq_o[7:0] carries bits 7..0 of the word at addr_i when lsb_i=0, and bits 15..8 when lsb_i=1.
- R3: In a byte read, dq_oe_o is 16'h00FF, so lanes 15..8 float.
- R4: With ce_ni=1, dq_oe_o is 16'h0000 whatever oe_ni and the other inputs are.
- R5: With ce_ni=0 and oe_ni=1, dq_oe_o is 16'h0000.
- R6: With ce_ni=0, oe_ni=0 and sig_hv_i=1, dq_o is 16'h0020 when addr_i[0]=0 and 16'h0032 when addr_i[0]=1, with dq_oe_o=16'hFFFF, in either width.
- R7: After reset every word reads 16'hFFFF.
- R8: A rising edge of ce_ni, sampled on clk_i, programs a word when it follows at least one sampled low cycle and, at that edge, prog_hv_i=1, oe_ni=1 and wide_i=1. The word at addr_i becomes its old value ANDed with din_i, and is visible from the next cycle.
- R9: While ce_ni stays high, no word changes, even with prog_hv_i=1 and oe_ni=1.
- R10: A ce_ni pulse that would program except that wide_i=0 leaves the memory unchanged and sets err_o. err_o stays 1 until reset.
- R11: A ce_ni pulse with oe_ni=1 but prog_hv_i=0 leaves the memory unchanged and does not set err_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, restores blank cells |
| addr_i | input | ADDR_W | Word address; bit 0 also picks the identifier entry |
| lsb_i | input | 1 | Half-word select in byte organisation (shared top pin) |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| wide_i | input | 1 | 1 = word organisation, 0 = byte organisation |
| sig_hv_i | input | 1 | High-voltage flag on the signature address pin |
| prog_hv_i | input | 1 | Program-voltage flag |
| din_i | input | 16 | Data presented for programming |
| dq_o | output | 16 | Data lanes |
| dq_oe_o | output | 16 | Per-lane drive enable |
| err_o | output | 1 | Sticky flag for a program attempt in byte organisation |

## Verification
A cell array that lost its reset state, or that wrote without ANDing, shows up on the very next read of that address. The bench therefore sweeps every address after reset, after a first program pass and after a second overlapping pass. A mode decoder or lane mux fault shows at once in dq_oe_o. The lanes are checked combinationally in each mode, with both half selects and both identifier entries. A fault in the program strobe shows as either a missing or an extra write. It is caught one cycle after the ce_ni rising edge, on a read of the target word and on err_o.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MAKER_ID = 8'h20;
  localparam logic [BYTE_W-1:0] PART_ID  = 8'h32;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_FLOAT,
    MD_WORD,
    MD_BYTE,
    MD_SIG
  } otp_mode_e;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_rom_pkg::*;
(
  input  logic      ce_ni,
  input  logic      oe_ni,
  input  logic      wide_i,
  input  logic      sig_hv_i,
  output otp_mode_e mode_o
);
  always_comb begin
    if (ce_ni)         mode_o = MD_STANDBY;
    else if (oe_ni)    mode_o = MD_FLOAT;
    else if (sig_hv_i) mode_o = MD_SIG;
    else if (wide_i)   mode_o = MD_WORD;
    else               mode_o = MD_BYTE;
  end
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic wide_i,
  input  logic prog_hv_i,
  output logic wr_en_o,
  output logic err_o
);
  logic ce_q;
  logic pulse_end;
  logic attempt;

  // end of a sampled low pulse on chip enable
  assign pulse_end = ~ce_q & ce_ni;
  assign attempt   = pulse_end & prog_hv_i & oe_ni;
  assign wr_en_o   = attempt & wide_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q  <= 1'b1;
      err_o <= 1'b0;
    end else begin
      ce_q <= ce_ni;
      if (attempt && !wide_i) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_rom_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en_i) begin
      // cells can only lose ones
      cells[addr_i] <= cells[addr_i] & wr_data_i;
    end
  end

  assign rd_data_o = cells[addr_i];
endmodule

// File: rtl/otp_lane_mux.sv
module otp_lane_mux
  import otp_rom_pkg::*;
(
  input  otp_mode_e         mode_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              lsb_i,
  input  logic              id_sel_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] dq_oe_o
);
  logic [BYTE_W-1:0] low_byte;

  always_comb begin
    low_byte = '0;
    unique case (mode_i)
      MD_BYTE: low_byte = lsb_i ? word_i[DATA_W-1:BYTE_W] : word_i[BYTE_W-1:0];
      MD_SIG:  low_byte = id_sel_i ? PART_ID : MAKER_ID;
      default: low_byte = '0;
    endcase
  end

  always_comb begin
    if (mode_i == MD_WORD) dq_o = word_i;
    else                   dq_o = {{(DATA_W-BYTE_W){1'b0}}, low_byte};
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    if (g < BYTE_W) begin : g_low
      assign dq_oe_o[g] = (mode_i == MD_WORD) || (mode_i == MD_BYTE) ||
                          (mode_i == MD_SIG);
    end else begin : g_high
      assign dq_oe_o[g] = (mode_i == MD_WORD) || (mode_i == MD_SIG);
    end
  end
endmodule

// File: rtl/otp_dual_rom.sv
module otp_dual_rom
  import otp_rom_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lsb_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              wide_i,
  input  logic              sig_hv_i,
  input  logic              prog_hv_i,
  input  logic [15:0]       din_i,
  output logic [15:0]       dq_o,
  output logic [15:0]       dq_oe_o,
  output logic              err_o
);
  otp_mode_e         mode;
  logic              wr_en;
  logic [DATA_W-1:0] word;

  otp_mode_dec u_dec (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .wide_i   (wide_i),
    .sig_hv_i (sig_hv_i),
    .mode_o   (mode)
  );

  otp_prog_ctrl u_prog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .oe_ni     (oe_ni),
    .wide_i    (wide_i),
    .prog_hv_i (prog_hv_i),
    .wr_en_o   (wr_en),
    .err_o     (err_o)
  );

  otp_cell_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cells (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .addr_i    (addr_i),
    .wr_data_i (din_i),
    .rd_data_o (word)
  );

  otp_lane_mux u_mux (
    .mode_i   (mode),
    .word_i   (word),
    .lsb_i    (lsb_i),
    .id_sel_i (addr_i[0]),
    .dq_o     (dq_o),
    .dq_oe_o  (dq_oe_o)
  );
endmodule

// File: rtl/otp_rom_chk.sv
module otp_rom_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        a0_i,
  input logic        ce_ni,
  input logic        oe_ni,
  input logic        wide_i,
  input logic        sig_hv_i,
  input logic        prog_hv_i,
  input logic [15:0] dq_o,
  input logic [15:0] dq_oe_o,
  input logic        err_o
);
  p_word_lanes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && !sig_hv_i && wide_i) |-> dq_oe_o == 16'hFFFF);

  p_byte_lanes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && !sig_hv_i && !wide_i) |->
      (dq_oe_o == 16'h00FF && dq_o[15:8] == 8'h00));

  p_standby_float_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> dq_oe_o == 16'h0000);

  p_oe_float_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && oe_ni) |-> dq_oe_o == 16'h0000);

  p_sig_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && sig_hv_i) |->
      (dq_o == (a0_i ? 16'h0032 : 16'h0020) && dq_oe_o == 16'hFFFF));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_err_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(prog_hv_i && oe_ni && !wide_i && ce_ni));
endmodule

bind otp_dual_rom otp_rom_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a0_i      (addr_i[0]),
  .ce_ni     (ce_ni),
  .oe_ni     (oe_ni),
  .wide_i    (wide_i),
  .sig_hv_i  (sig_hv_i),
  .prog_hv_i (prog_hv_i),
  .dq_o      (dq_o),
  .dq_oe_o   (dq_oe_o),
  .err_o     (err_o)
);

// File: tb/otp_dual_rom_bench.sv
`timescale 1ns/1ps
module otp_dual_rom_bench;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          lsb, ce_n, oe_n, wide, sig_hv, prog_hv;
  logic [15:0]   din;
  logic [15:0]   dq, dq_oe;
  logic          err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  otp_dual_rom #(.DEPTH(DEPTH)) u_otp_dual_rom (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .lsb_i (lsb),
    .ce_ni (ce_n), .oe_ni (oe_n), .wide_i (wide), .sig_hv_i (sig_hv),
    .prog_hv_i (prog_hv), .din_i (din), .dq_o (dq), .dq_oe_o (dq_oe),
    .err_o (err)
  );

  function automatic logic [15:0] pat_a(int a);
    return 16'(a * 40503) ^ 16'hC3A5;
  endfunction
  function automatic logic [15:0] pat_b(int a);
    return 16'(a * 7919) ^ 16'h0FF0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; sig_hv = 1'b0; prog_hv = 1'b0;
    wide = 1'b1; lsb = 1'b0; din = 16'hFFFF;
  endtask

  task automatic pulse_prog(input int a, input logic [15:0] d,
                            input logic w, input logic phv);
    @(negedge clk);
    addr = AW'(a); din = d; wide = w; prog_hv = phv; oe_n = 1'b1; ce_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    ce_n = 1'b1;
    @(posedge clk);
    idle();
  endtask

  task automatic rd(input int a, input logic w, input logic l, input logic s);
    @(negedge clk);
    addr = AW'(a); wide = w; lsb = l; sig_hv = s; prog_hv = 1'b0;
    ce_n = 1'b0; oe_n = 1'b0;
    #1;
  endtask

  task automatic sweep_words(input string tag, input int mode);
    for (int a = 0; a < DEPTH; a++) begin
      logic [15:0] e;
      e = (mode == 0) ? 16'hFFFF : (mode == 1) ? pat_a(a) : (pat_a(a) & pat_b(a));
      rd(a, 1'b1, 1'b0, 1'b0);
      chk(tag, {dq_oe, dq}, {16'hFFFF, e});
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; lsb = 1'b0; ce_n = 1'b1; oe_n = 1'b0;
    wide = 1'b1; sig_hv = 1'b0; prog_hv = 1'b0; din = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R4 reset standby lanes", {15'd0, err, dq_oe}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle();

    sweep_words("R7 blank after reset / R1 word read", 0);

    // R4: chip enable high, output enable low
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; wide = 1'b1; #1;
    chk("R4 standby oe low", {16'h0, dq_oe}, 32'h0);
    @(negedge clk); wide = 1'b0; sig_hv = 1'b1; #1;
    chk("R4 standby with sig", {16'h0, dq_oe}, 32'h0);
    idle();

    // R5: output disable
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); addr = AW'(a * 97); ce_n = 1'b0; oe_n = 1'b1;
      wide = a[0]; sig_hv = a[1]; #1;
      chk("R5 output disable", {16'h0, dq_oe}, 32'h0);
    end
    idle();

    // R9: chip enable held high with program conditions
    @(negedge clk); addr = AW'(5); din = 16'h0000; prog_hv = 1'b1; oe_n = 1'b1;
    wide = 1'b1; ce_n = 1'b1;
    repeat (6) @(posedge clk);
    idle();
    rd(5, 1'b1, 1'b0, 1'b0);
    chk("R9 inhibit keeps word", {16'h0, dq}, {16'h0, 16'hFFFF});

    // R11: pulse without program voltage
    pulse_prog(6, 16'h0000, 1'b1, 1'b0);
    rd(6, 1'b1, 1'b0, 1'b0);
    chk("R11 no voltage keeps word", {15'd0, err, dq}, {15'd0, 1'b0, 16'hFFFF});

    // R8: first pass then overlapping second pass
    for (int a = 0; a < DEPTH; a++) pulse_prog(a, pat_a(a), 1'b1, 1'b1);
    sweep_words("R8 first program pass", 1);
    for (int a = 0; a < DEPTH; a++) pulse_prog(a, pat_b(a), 1'b1, 1'b1);
    sweep_words("R8 second pass ANDs", 2);

    // R2 R3: byte reads of every address, both halves
    for (int a = 0; a < DEPTH; a++) begin
      for (int h = 0; h < 2; h++) begin
        logic [15:0] w;
        w = pat_a(a) & pat_b(a);
        rd(a, 1'b0, h[0], 1'b0);
        chk(h == 0 ? "R2 byte low half" : "R2 byte high half",
            {16'h0, dq}, {16'h0, 8'h00, (h == 0) ? w[7:0] : w[15:8]});
        chk("R3 byte lane enables", {16'h0, dq_oe}, {16'h0, 16'h00FF});
      end
    end

    // R6: identifier in both widths, other address bits varied
    for (int a = 0; a < 8; a++) begin
      rd(a * 37, a[2], a[1], 1'b1);
      chk("R6 identifier", {dq_oe, dq}, {16'hFFFF, (a[0] ? 16'h0032 : 16'h0020)});
    end

    // R10: byte-mode program attempt
    idle();
    chk("R10 err clear before", {31'd0, err}, 32'd0);
    pulse_prog(9, 16'h0000, 1'b0, 1'b1);
    rd(9, 1'b1, 1'b0, 1'b0);
    chk("R10 byte attempt ignored", {16'h0, dq}, {16'h0, pat_a(9) & pat_b(9)});
    chk("R10 err raised", {31'd0, err}, 32'd1);
    pulse_prog(10, 16'h0000, 1'b1, 1'b0);
    repeat (4) @(posedge clk);
    #1;
    chk("R10 err sticky", {31'd0, err}, 32'd1);

    // reset restores blank cells and clears the flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    idle();
    #1;
    chk("R10 err cleared by reset", {31'd0, err}, 32'd0);
    sweep_words("R7 blank after second reset", 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule